// File: doc/BRIEF.md
# SPI Configuration Programming Sequencer

This block sits on the host side of a configuration link and walks a target device through one complete programming session over its slave SPI port. A single start pulse, together with the total bitstream length in bytes, launches the session. The block then issues a fixed series of commands through a byte-level SPI master. Each command is one chip-select frame. The series opens the session and vets it with a four-byte readback, switches the target into program mode, streams the bitstream as 16-byte chunks, and closes with a timed release.

Before every chip-select frame the sequencer asks an external status-poll block for clearance and waits for its answer. Only one of these requests asks for the target's ready flag: the one ahead of the readback. A failed poll, a nonzero readback or a length that is not a whole number of chunks ends the session with an error. In each of these cases chip select goes low and the sequencer returns to idle. A program-mode flag on an output shows whether the target has been placed in program mode and not yet released.

Top module: `cfg_prog_seq`

## Requirements
- R1: A start whose `total_len` has any of bits [3:0] set raises `error` on the next cycle. No poll request and no chip-select frame follow.
- R2: The first chip-select frame of a session carries the single byte 0x0B.
- R3: The second frame carries 0x01 followed by four 0x00 bytes. The poll ahead of it is the only one in the session with `poll_need_ready` high. The received bytes 2 to 5 of that frame form the readback.
- R4: A readback with any nonzero bit raises `error` after that frame. No further frame is sent, and `prog_mode` stays low.
- R5: The third frame carries 0xAE, 0x01. `prog_mode` is low before that frame, rises after it, and is high at the start of every later frame.
- R6: For a length of N*16 bytes the block sends N frames of 17 bytes each. Every frame is 0xEE followed by the next 16 stream bytes in arrival order. A stream byte is consumed when `bs_ready` is high at a clock edge.
- R7: Every chip-select frame is preceded by a completed poll (`poll_done` high with `poll_fail` low). Chip select stays low while `poll_req` is high, and a session makes exactly as many polls as it sends frames.
- R8: `poll_fail` high together with `poll_done` raises `error`, stops the session before any further frame, and clears `prog_mode`.
- R9: After the program frames the block sends the single byte 0x0C. Chip select then stays low for at least CLK_HZ/1000 cycles before the final frame, the single byte 0x23.
- R10: When the final frame completes, `done` rises and `prog_mode` falls. `done` and `error` are levels that the next start clears, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Session start pulse, taken while idle |
| total_len | input | LEN_W | Bitstream length in bytes |
| bs_data | input | 8 | Bitstream byte |
| bs_valid | input | 1 | Bitstream byte available |
| bs_ready | output | 1 | Bitstream byte taken at this edge |
| poll_req | output | 1 | Request for a status poll |
| poll_need_ready | output | 1 | The poll must also see the ready flag |
| poll_done | input | 1 | Poll finished |
| poll_fail | input | 1 | Poll finished unsuccessfully |
| spi_cs | output | 1 | Chip select, high for the length of a frame |
| xfer_req | output | 1 | Request for one SPI byte exchange |
| xfer_tx | output | 8 | Byte to transmit |
| xfer_done | input | 1 | Byte exchange complete |
| xfer_rx | input | 8 | Byte received, valid with xfer_done |
| prog_mode | output | 1 | Target is in program mode |
| done | output | 1 | Session completed |
| error | output | 1 | Session aborted |

## Verification
The length rejection is due one cycle after the start edge, so the bench looks at `error` at the first falling edge after it. A good length must show `done` and `error` both low at that same edge. Each transmitted byte is logged at the falling edge where the SPI model raises `xfer_done`. The sequencer advances only at the next rising edge, so the logged value is the one that was really on `xfer_tx`. Chip-select edges, poll completions and the length of the release gap are counted at falling edges. The outcome of a session is judged only after `done` or `error` has held for a few further cycles, by which point any stray frame would already have shown up.

// File: rtl/cfg_seq_pkg.sv
// Shared types and command bytes of the configuration sequencer.
// Assumes bitstream chunks of 16 bytes behind a one-byte opcode.
package cfg_seq_pkg;

    localparam int CHUNK_LG = 4;

    typedef enum logic [1:0] {ST_IDLE, ST_POLL, ST_XFER, ST_WAIT} seq_state_e;

    typedef enum logic [2:0] {
        CM_ENABLE, CM_READ, CM_PMODE, CM_FRAME, CM_DISABLE, CM_RELEASE
    } seq_cmd_e;

    localparam logic [7:0] OP_ENABLE  = 8'h0B;
    localparam logic [7:0] OP_READ    = 8'h01;
    localparam logic [7:0] OP_PMODE0  = 8'hAE;
    localparam logic [7:0] OP_PMODE1  = 8'h01;
    localparam logic [7:0] OP_FRAME   = 8'hEE;
    localparam logic [7:0] OP_DISABLE = 8'h0C;
    localparam logic [7:0] OP_RELEASE = 8'h23;

    // Index of the last byte of each command frame.
    function automatic logic [4:0] cmd_last(seq_cmd_e c);
        case (c)
            CM_READ:  return 5'd4;
            CM_PMODE: return 5'd1;
            CM_FRAME: return 5'(1 << CHUNK_LG);
            default:  return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/cfg_seq_timer.sv
// One-shot delay timer: after a go pulse, fire is high in the cycle that
// completes CLK_HZ/1000 counted cycles (at least 1 ms at CLK_HZ).
// Assumes go is not pulsed again while running.
module cfg_seq_timer #(
    parameter int unsigned CLK_HZ = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic fire
);
    localparam int unsigned LIMIT = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);

    logic             running;
    logic [CNT_W-1:0] cnt;

    assign fire = running && (cnt == CNT_W'(LIMIT - 1));

    // Count cycles from go until the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (go) begin
            running <= 1'b1;
            cnt     <= '0;
        end else if (fire) begin
            running <= 1'b0;
        end else if (running) begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt < CNT_W'(LIMIT)));
    a_r9_fire_once: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !running);
endmodule

// File: rtl/cfg_seq_chunks.sv
// Chunk bookkeeping: judges whether a length is whole chunks and counts
// the chunks still to be sent. Assumes dec never comes when empty.
module cfg_seq_chunks
    import cfg_seq_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] total_len,
    input  logic             load,
    input  logic             dec,
    output logic             len_ok,
    output logic             none_left,
    output logic             one_left
);
    localparam int CNT_W = LEN_W - CHUNK_LG;

    logic [CNT_W-1:0] left;

    assign len_ok    = (total_len[CHUNK_LG-1:0] == '0);
    assign none_left = (left == '0);
    assign one_left  = (left == CNT_W'(1));

    // Load the chunk count at session start, step down per frame sent.
    always_ff @(posedge clk) begin
        if (!rst_n)    left <= '0;
        else if (load) left <= total_len[LEN_W-1:CHUNK_LG];
        else if (dec)  left <= left - 1'b1;
    end

    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !none_left);
endmodule

// File: rtl/cfg_prog_seq.sv
// Programming-session sequencer. Polls for clearance before every
// chip-select frame, then sends: enable, readback, program mode,
// N data chunks, disable, timed gap, release. Assumes the SPI master
// raises xfer_done for one cycle per exchanged byte, and the poll block
// raises poll_done for one cycle per request.
module cfg_prog_seq
    import cfg_seq_pkg::*;
#(
    parameter int          LEN_W  = 16,
    parameter int unsigned CLK_HZ = 100_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] total_len,
    input  logic [7:0]       bs_data,
    input  logic             bs_valid,
    output logic             bs_ready,
    output logic             poll_req,
    output logic             poll_need_ready,
    input  logic             poll_done,
    input  logic             poll_fail,
    output logic             spi_cs,
    output logic             xfer_req,
    output logic [7:0]       xfer_tx,
    input  logic             xfer_done,
    input  logic [7:0]       xfer_rx,
    output logic             prog_mode,
    output logic             done,
    output logic             error
);
    seq_state_e state;
    seq_cmd_e   cmd;
    logic [4:0] idx;
    logic [7:0] rd_acc;

    logic is_data, byte_done, last_byte, timer_go, timer_fire;
    logic cnt_load, cnt_dec, len_ok, none_left, one_left;

    // Frame-level handshakes derived from the state.
    assign is_data         = (state == ST_XFER) && (cmd == CM_FRAME) && (idx != '0);
    assign spi_cs          = (state == ST_XFER);
    assign xfer_req        = spi_cs && (!is_data || bs_valid);
    assign bs_ready        = is_data && xfer_done;
    assign poll_req        = (state == ST_POLL);
    assign poll_need_ready = poll_req && (cmd == CM_READ);
    assign byte_done       = spi_cs && xfer_done;
    assign last_byte       = (idx == cmd_last(cmd));
    assign timer_go        = byte_done && last_byte && (cmd == CM_DISABLE);
    assign cnt_load        = (state == ST_IDLE) && start && len_ok;
    assign cnt_dec         = byte_done && last_byte && (cmd == CM_FRAME);

    // Byte to transmit for the current command and position.
    always_comb begin
        case (cmd)
            CM_ENABLE:  xfer_tx = OP_ENABLE;
            CM_READ:    xfer_tx = (idx == '0) ? OP_READ : 8'h00;
            CM_PMODE:   xfer_tx = (idx == '0) ? OP_PMODE0 : OP_PMODE1;
            CM_FRAME:   xfer_tx = (idx == '0) ? OP_FRAME : bs_data;
            CM_DISABLE: xfer_tx = OP_DISABLE;
            default:    xfer_tx = OP_RELEASE;
        endcase
    end

    cfg_seq_chunks #(.LEN_W(LEN_W)) u_chunks (
        .clk(clk), .rst_n(rst_n), .total_len(total_len),
        .load(cnt_load), .dec(cnt_dec),
        .len_ok(len_ok), .none_left(none_left), .one_left(one_left)
    );

    cfg_seq_timer #(.CLK_HZ(CLK_HZ)) u_timer (
        .clk(clk), .rst_n(rst_n), .go(timer_go), .fire(timer_fire)
    );

    // Session state machine: poll, send frame, pick the next command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cmd       <= CM_ENABLE;
            idx       <= '0;
            rd_acc    <= '0;
            prog_mode <= 1'b0;
            done      <= 1'b0;
            error     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    done  <= 1'b0;
                    error <= !len_ok;
                    cmd   <= CM_ENABLE;
                    if (len_ok) state <= ST_POLL;
                end
                ST_POLL: if (poll_done) begin
                    idx    <= '0;
                    rd_acc <= '0;
                    if (poll_fail) begin
                        error     <= 1'b1;
                        prog_mode <= 1'b0;
                        state     <= ST_IDLE;
                    end else begin
                        state <= ST_XFER;
                    end
                end
                ST_XFER: if (xfer_done) begin
                    if (cmd == CM_READ && idx != '0) rd_acc <= rd_acc | xfer_rx;
                    if (!last_byte) begin
                        idx <= idx + 1'b1;
                    end else begin
                        state <= ST_POLL;
                        case (cmd)
                            CM_ENABLE: cmd <= CM_READ;
                            CM_READ: begin
                                if ((rd_acc | xfer_rx) != 8'h00) begin
                                    error <= 1'b1;
                                    state <= ST_IDLE;
                                end
                                cmd <= CM_PMODE;
                            end
                            CM_PMODE: begin
                                prog_mode <= 1'b1;
                                cmd       <= none_left ? CM_DISABLE : CM_FRAME;
                            end
                            CM_FRAME: if (one_left) cmd <= CM_DISABLE;
                            CM_DISABLE: state <= ST_WAIT;
                            default: begin
                                prog_mode <= 1'b0;
                                done      <= 1'b1;
                                state     <= ST_IDLE;
                            end
                        endcase
                    end
                end
                default: if (timer_fire) begin
                    cmd   <= CM_RELEASE;
                    state <= ST_POLL;
                end
            endcase
        end
    end

    a_r7_cs_quiet_in_poll: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |-> !spi_cs);
    a_r6_req_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> spi_cs);
    a_r8_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> (!spi_cs && !prog_mode));
    a_r10_done_error_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));
    a_r5_pm_after_pmode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_mode) |-> $past(cmd == CM_PMODE));
    a_r1_bad_len_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && total_len[3:0] != 4'h0) |=> (error && !poll_req));
endmodule

// File: tb/cfg_prog_seq_tb.sv
module cfg_prog_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HZ    = 10_000;
    localparam int GAP   = HZ / 1000;
    localparam int LAT   = 2;
    localparam int PLAT  = 3;
    localparam int LOGN  = 512;

    logic        clk = 0, rst_n = 0, start = 0;
    logic [15:0] total_len = 0;
    logic [7:0]  bs_data = 0, xfer_rx = 0;
    logic        bs_valid = 1, poll_done = 0, poll_fail = 0, xfer_done = 0;
    logic        bs_ready, poll_req, poll_need_ready, spi_cs, xfer_req;
    logic [7:0]  xfer_tx;
    logic        prog_mode, done, error;

    cfg_prog_seq #(.LEN_W(16), .CLK_HZ(HZ)) u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    // model state
    int   nb, nfr, npoll, nready, fail_at, xcnt, pcnt, bs_cnt, fpos, pm_bad;
    int   t_dis, gap_seen;
    logic bs_pend, csp;
    logic [7:0]  ffirst;
    logic [31:0] rb;
    logic [7:0]  lg [LOGN];

    function automatic logic [7:0] pat(int k);
        return 8'((k * 7 + 3) & 8'hFF);
    endfunction

    function automatic int flen(int i, int n);
        if (i == 0) return 1;
        if (i == 1) return 5;
        if (i == 2) return 2;
        if (i < 3 + n) return 17;
        return 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Negedge models of the SPI master, the poll block and the stream source.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
        if (rst_n) begin
            if (spi_cs && !csp) begin
                if (npoll != nfr + 1) pm_bad += 100; // R7 poll before frame
                if (prog_mode != (nfr >= 3)) pm_bad++;
                nfr++; fpos = 0;
                if (t_dis >= 0) begin gap_seen = cyc - t_dis; t_dis = -1; end
            end
            if (!spi_cs && csp && ffirst == 8'h0C) t_dis = cyc;
            csp = spi_cs;
            if (xfer_done) begin
                xfer_done = 0; xcnt = 0;
                if (bs_pend) begin bs_cnt++; bs_pend = 0; end
                bs_data = pat(bs_cnt);
            end else if (xfer_req) begin
                xcnt++;
                if (xcnt >= LAT) begin
                    if (fpos == 0) ffirst = xfer_tx;
                    if (nb < LOGN) lg[nb] = xfer_tx;
                    nb++;
                    xfer_rx = (ffirst == 8'h01 && fpos >= 1) ? rb[8*(fpos-1) +: 8] : 8'h00;
                    if (ffirst == 8'hEE && fpos >= 1) bs_pend = 1;
                    fpos++;
                    xfer_done = 1;
                end
            end
            if (poll_done) begin
                poll_done = 0; poll_fail = 0; pcnt = 0;
            end else if (poll_req) begin
                pcnt++;
                if (pcnt >= PLAT) begin
                    poll_fail = (npoll == fail_at);
                    if (poll_need_ready) nready++;
                    npoll++;
                    poll_done = 1;
                end
            end
        end
    end

    task automatic session(input int len, input int fa, input logic [31:0] rbv);
        int n, exp_fr, exp_b, w, k, pos, dpos, bad;
        nb = 0; nfr = 0; npoll = 0; nready = 0; pm_bad = 0; fail_at = fa;
        t_dis = -1; gap_seen = 0; bs_cnt = 0; bs_pend = 0; rb = rbv; ffirst = 0;
        bs_data = pat(0);
        n = len / 16;
        @(negedge clk); total_len = 16'(len); start = 1;
        @(negedge clk); start = 0;
        if (len % 16 != 0) begin
            chk(error == 1 && done == 0, "R1 error next cycle", error, 1);
        end else begin
            chk(error == 0 && done == 0, "R10 levels cleared by start", {done, error}, 0);
        end
        w = 0;
        while (!done && !error && w < 4000) begin @(negedge clk); w++; end
        repeat (4) @(negedge clk);
        if (len % 16 != 0) begin
            chk(nb == 0 && npoll == 0, "R1 no poll or byte", nb + npoll, 0);
            return;
        end
        if (fa >= 0) exp_fr = fa;
        else if (rbv != 0) exp_fr = 2;
        else exp_fr = n + 5;
        exp_b = 0;
        for (int i = 0; i < exp_fr; i++) exp_b += flen(i, n);
        chk(nfr == exp_fr, "R7/R8 frame count", nfr, exp_fr);
        chk(nb == exp_b, "R6 byte count", nb, exp_b);
        chk(pm_bad == 0, "R5/R7 prog_mode and poll order at frame starts", pm_bad, 0);
        chk(prog_mode == 0, "R10/R8 prog_mode low at end", prog_mode, 0);
        if (fa >= 0 || rbv != 0) begin
            chk(error == 1 && done == 0, "R4/R8 error raised", error, 1);
            chk(npoll == ((fa >= 0) ? fa + 1 : 2), "R8 polls stop", npoll, (fa >= 0) ? fa + 1 : 2);
        end else begin
            chk(done == 1 && error == 0, "R10 done raised", done, 1);
            chk(npoll == n + 5, "R7 one poll per frame", npoll, n + 5);
            chk(nready == 1, "R3 single ready poll", nready, 1);
            chk(gap_seen >= GAP, "R9 release gap", gap_seen, GAP);
        end
        // Compare every logged byte with the arithmetic expectation.
        bad = -1; pos = 0; dpos = 0;
        for (int i = 0; i < exp_fr && pos < nb && pos < LOGN; i++) begin
            for (k = 0; k < flen(i, n); k++) begin
                logic [7:0] e;
                if (i == 0) e = 8'h0B;
                else if (i == 1) e = (k == 0) ? 8'h01 : 8'h00;
                else if (i == 2) e = (k == 0) ? 8'hAE : 8'h01;
                else if (i < 3 + n) begin
                    if (k == 0) e = 8'hEE; else begin e = pat(dpos); dpos++; end
                end
                else if (i == 3 + n) e = 8'h0C;
                else e = 8'h23;
                if (pos < nb && lg[pos] != e && bad < 0) begin
                    bad = pos;
                    $display("FAIL R2/R3/R5/R6/R9 byte %0d: actual %0d expected %0d", pos, lg[pos], e);
                end
                pos++;
            end
        end
        checks++;
        if (bad >= 0) fails++;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!spi_cs && !poll_req && !done && !error && !prog_mode && !xfer_req,
            "reset state", {spi_cs, poll_req, done, error, prog_mode}, 0);
        rst_n = 1;
        // R1/R6/R10: sweep every length 0..48
        for (int L = 0; L <= 48; L++) session(L, -1, 32'h0);
        // R4: a nonzero bit in each readback byte
        for (int b = 0; b < 4; b++) session(32, -1, 32'h1 << (8 * b + b));
        // R8: poll failure at every poll position of a two-chunk session
        for (int f = 0; f < 7; f++) session(32, f, 32'h0);
        // R10: a clean session after an aborted one
        session(16, -1, 32'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule